// File: doc/BRIEF.md
# Three-Wire Framed Serial Register Target

This block is the target end of a three-wire serial link through which an external controller reads and writes a small bank of 12-bit registers. The controller always starts a transfer. It raises a frame strobe, clocks in a 12-bit instruction word and then any number of 12-bit data words, and lowers the strobe to close the packet. The instruction carries a direction flag and an 11-bit start address. Each data word moves to or from the next address in turn.

The three serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the serial clock edges are found in the system clock domain. During a read, the target drives the returned bits out on a separate data output and raises an output enable, which a pad can use to turn the shared wire around. The register contents are presented in parallel for the logic that consumes them.

No stream interface exists here: all pins are plain control and data, so no back-pressure rule applies.

Top module: `ser3_target`

## Requirements
- R1: An instruction word is 12 bits, sent MSB first and sampled on each rising serial clock edge. Bit 11 = 1 selects a read and 0 selects a write. Bits 10:0 give the start address.
- R2: In a write frame, each complete 12-bit data word is stored at the current address, and the address then steps up by one. Register i appears on `regs_o[12*i +: 12]`.
- R3: While the frame strobe is low, serial clock and data activity changes no register and does not enable the output.
- R4: A data word that is cut short by the strobe falling is discarded. No register changes.
- R5: In a read frame, the first falling serial clock edge after the instruction's last rising edge puts bit 11 of the addressed register on `ser_dat_o`. Each later falling edge presents the next lower bit. Consecutive words come from consecutive addresses.
- R6: `ser_dat_oe_o` rises only in the data phase of a read frame and is low again 3 system cycles after the strobe falls. While it is low, `ser_dat_o` is 0.
- R7: A write to an address of DEPTH or more is dropped, and a read from such an address returns 0.
- R8: A serial pin change takes effect on the outputs at the 3rd rising system clock edge after the change.
- R9: While `rst_n` is low, all registers are cleared to 0 and the output enable and data output are 0, without waiting for a clock.
- R10: Data words clocked in during a read frame write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_sync_i | input | 1 | Frame strobe, high for the length of one packet |
| ser_clk_i | input | 1 | Serial clock from the controller |
| ser_dat_i | input | 1 | Serial data from the controller |
| ser_dat_o | output | 1 | Serial read data to the controller |
| ser_dat_oe_o | output | 1 | High while the target drives the data wire |
| regs_o | output | DEPTH*12 | Parallel register contents, register i at bits 12*i+11:12*i |

## Verification
Every serial pin change reaches the registers and the output enable at the third rising system edge after the bench drives it. That is two synchroniser stages plus the register that takes the action. The bench drives pins at falling system edges and waits exactly three rising edges before it updates its behavioural model, so a result that is early or late by one cycle shows up at the next comparison. The bench compares the register bank, the enable and the idle data level against the model at every falling system edge. Read data is gathered at each serial rising edge, just as a controller would sample it, and checked word by word against the model's bank.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  localparam int WORD_W = 12;
  typedef enum logic { PH_INSTR, PH_DATA } phase_t;
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/ser3_frame.sv
module ser3_frame
  import ser3_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_i,
  input  logic          ck_i,
  input  logic          di_i,
  input  logic [W-1:0]  rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o,
  output logic          dout_o,
  output logic          oe_o
);
  localparam int CW = $clog2(W);

  logic          ck_q;
  logic          ck_rise, ck_fall;
  logic [CW-1:0] bit_cnt;
  logic [W-2:0]  shreg;
  logic [W-1:0]  word_in;
  logic          word_done;
  phase_t        phase;
  logic          rd_mode;
  logic [AW-1:0] addr;
  logic [W-1:0]  osh;

  assign ck_rise   = ck_i & ~ck_q;
  assign ck_fall   = ~ck_i & ck_q;
  assign word_in   = {shreg, di_i};
  assign word_done = (bit_cnt == CW'(W - 1));

  // The instruction word addresses the first read; later words use the running address.
  assign rd_addr_o = (phase == PH_INSTR) ? word_in[AW-1:0] : addr;
  assign wr_en_o   = fs_i & ck_rise & word_done & (phase == PH_DATA) & ~rd_mode;
  assign wr_addr_o = addr;
  assign wr_data_o = word_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ck_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      phase   <= PH_INSTR;
      rd_mode <= 1'b0;
      addr    <= '0;
      osh     <= '0;
      dout_o  <= 1'b0;
      oe_o    <= 1'b0;
    end else if (!fs_i) begin
      // Outside a frame: drop any partial word and release the line.
      bit_cnt <= '0;
      phase   <= PH_INSTR;
      dout_o  <= 1'b0;
      oe_o    <= 1'b0;
    end else if (ck_rise) begin
      shreg <= word_in[W-2:0];
      if (word_done) begin
        bit_cnt <= '0;
        if (phase == PH_INSTR) begin
          phase   <= PH_DATA;
          rd_mode <= word_in[W-1];
          if (word_in[W-1]) begin
            osh  <= rd_data_i;
            addr <= word_in[AW-1:0] + AW'(1);
          end else begin
            addr <= word_in[AW-1:0];
          end
        end else begin
          addr <= addr + AW'(1);
          if (rd_mode) osh <= rd_data_i;
        end
      end else begin
        bit_cnt <= bit_cnt + CW'(1);
      end
    end else if (ck_fall && phase == PH_DATA && rd_mode) begin
      oe_o   <= 1'b1;
      dout_o <= osh[W-1];
      osh    <= {osh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ser3_regfile.sv
module ser3_regfile #(
  parameter int W     = 12,
  parameter int AW    = 11,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [W-1:0]     rd_data_o,
  output logic [DEPTH*W-1:0] regs_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))        q <= wr_data_i;
    end
    assign regs_o[g*W +: W] = q;
  end

  // Addresses at or beyond DEPTH match no entry and read as zero.
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = regs_o[i*W +: W];
  end
endmodule

// File: rtl/ser3_target.sv
module ser3_target
  import ser3_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int W    = WORD_W,
  localparam int AW   = W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_sync_i,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  output logic               ser_dat_o,
  output logic               ser_dat_oe_o,
  output logic [DEPTH*W-1:0] regs_o
);
  logic          fs_s, ck_s, di_s;
  logic [W-1:0]  rd_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [W-1:0]  wr_data;
  logic          wr_en;

  ser3_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({frm_sync_i, ser_clk_i, ser_dat_i}),
    .sync_o  ({fs_s, ck_s, di_s})
  );

  ser3_frame #(.W(W), .AW(AW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_i      (fs_s),
    .ck_i      (ck_s),
    .di_i      (di_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .dout_o    (ser_dat_o),
    .oe_o      (ser_dat_oe_o)
  );

  ser3_regfile #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/ser3_target_chk.sv
module ser3_target_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 12,
  parameter int AW    = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fs_s,
  input logic               ck_s,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic               ser_dat_o,
  input logic               ser_dat_oe_o,
  input logic [DEPTH*W-1:0] regs_o
);
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fs_s && ck_s)); // R3

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R4

  AST_HIGH_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(DEPTH)) |=> $stable(regs_o)); // R7

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_s |=> !ser_dat_oe_o); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dat_oe_o |-> !ser_dat_o); // R6

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dat_oe_o) |-> (!$past(ck_s) && $past(ck_s, 2))); // R5
endmodule

bind ser3_target ser3_target_chk #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fs_s         (fs_s),
  .ck_s         (ck_s),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .ser_dat_o    (ser_dat_o),
  .ser_dat_oe_o (ser_dat_oe_o),
  .regs_o       (regs_o)
);

// File: tb/ser3_target_tb.sv
module ser3_target_tb;
  localparam int DEPTH = 8;
  localparam int W     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sfs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, soe;
  logic [DEPTH*W-1:0] regs;

  always #2 clk = ~clk;   // 250 MHz

  ser3_target #(.DEPTH(DEPTH)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .frm_sync_i (sfs), .ser_clk_i (sck), .ser_dat_i (sdi),
    .ser_dat_o (sdo), .ser_dat_oe_o (soe), .regs_o (regs)
  );

  // Behavioural model
  logic [W-1:0] mreg [DEPTH];
  logic         m_oe = 1'b0;
  logic [W-1:0] wq [$];
  logic [W-1:0] rq [$];
  logic [W-1:0] eq [$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DEPTH*W-1:0] model_flat();
    logic [DEPTH*W-1:0] f;
    for (int i = 0; i < DEPTH; i++) f[i*W +: W] = mreg[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [DEPTH*W-1:0] act, input logic [DEPTH*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison (R8 timing: the model changes at the 3rd rising edge after each pin change)
  always @(negedge clk) if (!done) begin
    check("R2/R8 regs", regs, model_flat());
    check("R6 oe", {{(DEPTH*W-1){1'b0}}, soe}, {{(DEPTH*W-1){1'b0}}, m_oe});
    if (!m_oe) check("R6 idle data", {{(DEPTH*W-1){1'b0}}, sdo}, '0);
  end

  task automatic rise_bit(input logic b, output logic smp);
    @(negedge clk); sdi = b;
    repeat (3) @(negedge clk);
    smp = sdo; sck = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic fall_clk();
    repeat (3) @(negedge clk); sck = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic run_frame(input logic rd, input int addr, input int nwords, input int tail);
    logic [W-1:0] ins, acc, dw;
    logic smp;
    int a;
    ins = {rd, 11'(addr)};
    a = addr;
    @(negedge clk); sfs = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      rise_bit(ins[W-1-i], smp);
      fall_clk();
      if (i == W - 1 && rd) m_oe = 1'b1;
    end
    for (int w = 0; w < nwords; w++) begin
      acc = '0;
      dw  = (w < wq.size()) ? wq[w] : 12'hA5A;
      for (int i = 0; i < W; i++) begin
        rise_bit(dw[W-1-i], smp);
        acc = {acc[W-2:0], smp};
        if (i == W - 1) begin
          if (rd) eq.push_back((a < DEPTH) ? mreg[a] : '0);
          else if (a < DEPTH) mreg[a] = dw;
          a = (a + 1) & 12'h7FF;
        end
        fall_clk();
      end
      if (rd) rq.push_back(acc);
    end
    for (int i = 0; i < tail; i++) begin
      rise_bit(1'b1, smp);
      fall_clk();
    end
    @(negedge clk); sfs = 1'b0;
    repeat (3) @(posedge clk);
    m_oe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_reads(input string req);
    while (rq.size() > 0) begin
      logic [W-1:0] r, e;
      r = rq.pop_front();
      e = eq.pop_front();
      check(req, {{(DEPTH*W-W){1'b0}}, r}, {{(DEPTH*W-W){1'b0}}, e});
    end
  endtask

  initial begin
    logic [DEPTH*W-1:0] snap;
    for (int i = 0; i < DEPTH; i++) mreg[i] = '0;
    repeat (5) @(negedge clk);
    // R9: reset state
    check("R9 reset regs", regs, '0);
    check("R9 reset oe", {{(DEPTH*W-1){1'b0}}, soe}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R2: write three words from address 1
    wq = '{12'h123, 12'hABC, 12'h800};
    run_frame(1'b0, 1, 3, 0);
    check("R2 write burst", regs, model_flat());

    // R5, R1: read four words from address 0
    wq.delete();
    run_frame(1'b1, 0, 4, 0);
    check_reads("R5 read burst");

    // R3: serial activity with the strobe low
    snap = regs;
    for (int i = 0; i < 30; i++) begin
      logic smp;
      rise_bit(1'b1, smp);
      fall_clk();
    end
    check("R3 no frame no write", regs, snap);

    // R4: one full word then a 7-bit partial word at address 5
    wq = '{12'h5C3, 12'hFFF};
    run_frame(1'b0, 5, 1, 7);
    check("R4 partial dropped", regs, model_flat());

    // R7: write across the top of the bank, then read beyond it
    wq = '{12'h77E, 12'h999};
    run_frame(1'b0, 7, 2, 0);
    check("R7 high write dropped", regs, model_flat());
    wq.delete();
    run_frame(1'b1, 6, 3, 0);
    check_reads("R7 high read zero");
    run_frame(1'b1, 12'h7FF, 2, 0);
    check_reads("R7 top address wrap read");

    // R10: data pins active during a read frame
    snap = regs;
    wq = '{12'h0F0, 12'h3C3};
    run_frame(1'b1, 2, 2, 0);
    check_reads("R10 read during junk");
    check("R10 read frame no write", regs, snap);

    // R9: reset mid-run clears everything
    @(posedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) mreg[i] = '0;
    m_oe = 1'b0;
    @(negedge clk);
    check("R9 reset clears", regs, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R2 after reset: single word at address 4, read back
    wq = '{12'h4D2};
    run_frame(1'b0, 4, 1, 0);
    wq.delete();
    run_frame(1'b1, 3, 2, 0);
    check_reads("R1 after reset read");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule